// File: doc/BRIEF.md
# Multi-Core Interrupt Acknowledge Arbiter

This block is a small interrupt distributor for two to four processor cores. It keeps pending and active state for every interrupt ID. Each core can read the lowest interrupt ID that is ready for it, claim that ID with an acknowledge strobe, and later release it with a deactivate write. The low IDs are private. Each core has its own source lines and its own state for them, so every core can take them independently. The upper IDs are shared lines. Only one core may hold a shared interrupt at any time.

When a core claims a shared interrupt, the single pending indication for that line is consumed on behalf of all cores. Every other core then reads the spurious ID until the owner deactivates it. A configuration bit for each ID selects level or edge behaviour. If two cores claim the same shared ID in the same cycle, the lower core index wins.

Top module: `irqarb_top`

## Requirements
- R1: After reset nothing is pending or active, and every core's `ackId` reads 1023.
- R2: `ackId` for a core shows the lowest ID that is pending, enabled and not active for that core, or 1023 if there is none. The view includes the core's own private IDs and all shared IDs. Private IDs are 0 to NUM_PRIV-1, fed by `privSrc[c*NUM_PRIV+p]`. Shared IDs are NUM_PRIV and up, fed by `sharedSrc[id-NUM_PRIV]`. Core c's field is `ackId[c*10 +: 10]`.
- R3: While a shared ID is active on one core, no core is offered that ID. Acknowledge reads on the other cores return 1023 for it until it is deactivated.
- R4: An acknowledge at a clock edge makes the offered ID active. If the source is still requesting, the ID stays pending as well (active and pending). In that case it is offered again right after the edge that deactivates it.
- R5: For a level-sensitive shared ID, one core's acknowledge consumes the pending state for all cores. Other cores read 1023 even while the line stays high.
- R6: Private IDs keep separate pending and active state on each core. Acknowledging private ID p on one core leaves the same ID on other cores untouched.
- R7: Bit `irqIsLevel[id]`=1 selects level behaviour: pending follows the line, registered once. Bit 0 selects edge behaviour: a 0-to-1 transition latches pending, which holds after the line falls and is cleared by acknowledge.
- R8: If several cores request the same shared ID in one cycle, the lowest-index requesting core is granted. Every other requesting core sees 1023 in that cycle.
- R9: A deactivate write naming an ID that is not active on the writing core has no effect.
- R10: An ID is offered only while both `globalEn` and `irqEnable[id]` are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| globalEn | input | 1 | Global distributor enable |
| irqEnable | input | NUM_PRIV+NUM_SHARED | Per-ID enable |
| irqIsLevel | input | NUM_PRIV+NUM_SHARED | Per-ID trigger mode, 1 = level |
| privSrc | input | NUM_CORES*NUM_PRIV | Private source lines, core-major |
| sharedSrc | input | NUM_SHARED | Shared source lines |
| ackReq | input | NUM_CORES | Acknowledge strobe per core |
| ackId | output | NUM_CORES*10 | Offered or granted ID per core, 1023 = spurious |
| deactReq | input | NUM_CORES | Deactivate strobe per core |
| deactId | input | NUM_CORES*10 | ID to deactivate, per core |

## Verification
The hardest state to reach is active-and-pending on an edge-triggered shared ID. The stimulus gets there in three steps: latch a pulse, claim the ID from one core, then pulse the line again while the ID is still active. It then checks that the ID returns only after the owner's deactivate and does not return a second time. A same-cycle claim collision between two non-zero cores is also driven. So is a deactivate from a core that does not own the interrupt, checked while the line is held high, so that a wrongly applied release would show up as the ID reappearing.

// File: rtl/irqarb_pkg.sv
package irqarb_pkg;
  localparam int ID_W = 10;
  localparam logic [ID_W-1:0] SPURIOUS_ID = 10'd1023;

  typedef struct packed {
    logic            ack;
    logic [ID_W-1:0] ackId;
    logic            deact;
    logic [ID_W-1:0] deactId;
  } coreStrobe_t;
endpackage

// File: rtl/irqarb_state.sv
module irqarb_state
  import irqarb_pkg::*;
#(
  parameter int NUM_CORES  = 3,
  parameter int NUM_PRIV   = 4,
  parameter int NUM_SHARED = 4
) (
  input  logic                                   clk,
  input  logic                                   rstN,
  input  logic                                   globalEn,
  input  logic [NUM_PRIV+NUM_SHARED-1:0]         irqEnable,
  input  logic [NUM_PRIV+NUM_SHARED-1:0]         irqIsLevel,
  input  logic [NUM_CORES*NUM_PRIV-1:0]          privSrc,
  input  logic [NUM_SHARED-1:0]                  sharedSrc,
  input  coreStrobe_t [NUM_CORES-1:0]            strobes,
  output logic [NUM_CORES-1:0][NUM_PRIV+NUM_SHARED-1:0] present,
  output logic [NUM_CORES-1:0][NUM_PRIV+NUM_SHARED-1:0] activeOn
);
  localparam int NUM_IRQ = NUM_PRIV + NUM_SHARED;
  localparam int OW = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1;

  logic [NUM_IRQ-1:0] idEn;
  assign idEn = irqEnable & {NUM_IRQ{globalEn}};

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    for (genvar p = 0; p < NUM_PRIV; p++) begin : g_priv
      logic pend, act, prev, line, ackHit, deactHit;
      assign line     = privSrc[c*NUM_PRIV+p];
      assign ackHit   = strobes[c].ack && (strobes[c].ackId == ID_W'(p));
      assign deactHit = strobes[c].deact && (strobes[c].deactId == ID_W'(p));

      always_ff @(posedge clk) begin
        if (!rstN) begin
          pend <= 1'b0;
          act  <= 1'b0;
          prev <= 1'b0;
        end else begin
          prev <= line;
          pend <= irqIsLevel[p] ? line : ((line & ~prev) | (pend & ~ackHit));
          act  <= ackHit | (act & ~deactHit);
        end
      end

      assign present[c][p]  = idEn[p] & pend & ~act;
      assign activeOn[c][p] = act;

      assert_deact_valid_R9: assert property (@(posedge clk) disable iff (!rstN)
        deactHit |-> act);
    end
  end

  for (genvar s = 0; s < NUM_SHARED; s++) begin : g_shared
    localparam int ID = NUM_PRIV + s;
    logic pend, act, prev, line, ackAny, deactHit;
    logic [NUM_CORES-1:0] ackVec, deactVec;
    logic [OW-1:0] owner, ackOwner;

    assign line = sharedSrc[s];

    always_comb begin
      ackOwner = '0;
      for (int c = NUM_CORES - 1; c >= 0; c--) begin
        ackVec[c]   = strobes[c].ack && (strobes[c].ackId == ID_W'(ID));
        deactVec[c] = strobes[c].deact && (strobes[c].deactId == ID_W'(ID))
                      && (owner == OW'(c));
        if (ackVec[c]) ackOwner = OW'(c);
      end
    end
    assign ackAny   = |ackVec;
    assign deactHit = act & (|deactVec);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        pend  <= 1'b0;
        act   <= 1'b0;
        prev  <= 1'b0;
        owner <= '0;
      end else begin
        prev <= line;
        pend <= irqIsLevel[ID] ? line : ((line & ~prev) | (pend & ~ackAny));
        act  <= ackAny | (act & ~deactHit);
        if (ackAny) owner <= ackOwner;
      end
    end

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_view
      assign present[c][ID]  = idEn[ID] & pend & ~act;
      assign activeOn[c][ID] = act && (owner == OW'(c));
    end

    assert_single_claim_R3: assert property (@(posedge clk) disable iff (!rstN)
      $onehot0(ackVec));
    assert_ack_activates_R4: assert property (@(posedge clk) disable iff (!rstN)
      ackAny |=> (act && owner == $past(ackOwner)));
  end
endmodule

// File: rtl/irqarb_ctrl.sv
module irqarb_ctrl
  import irqarb_pkg::*;
#(
  parameter int NUM_CORES  = 3,
  parameter int NUM_PRIV   = 4,
  parameter int NUM_SHARED = 4
) (
  input  logic                                   clk,
  input  logic                                   rstN,
  input  logic [NUM_CORES-1:0]                   ackReq,
  input  logic [NUM_CORES-1:0]                   deactReq,
  input  logic [NUM_CORES*ID_W-1:0]              deactIdFlat,
  input  logic [NUM_CORES-1:0][NUM_PRIV+NUM_SHARED-1:0] present,
  input  logic [NUM_CORES-1:0][NUM_PRIV+NUM_SHARED-1:0] activeOn,
  output logic [NUM_CORES*ID_W-1:0]              ackIdFlat,
  output coreStrobe_t [NUM_CORES-1:0]            strobes
);
  localparam int NUM_IRQ = NUM_PRIV + NUM_SHARED;

  logic [NUM_CORES-1:0][ID_W-1:0] pick;
  logic [NUM_CORES-1:0] found, lose, deactOk;

  always_comb begin
    for (int c = 0; c < NUM_CORES; c++) begin
      pick[c]  = SPURIOUS_ID;
      found[c] = 1'b0;
      for (int i = NUM_IRQ - 1; i >= 0; i--) begin
        if (present[c][i]) begin
          pick[c]  = ID_W'(i);
          found[c] = 1'b1;
        end
      end
    end
    for (int c = 0; c < NUM_CORES; c++) begin
      lose[c] = 1'b0;
      for (int k = 0; k < c; k++) begin
        if (ackReq[k] && found[k] && found[c] && (pick[k] == pick[c])
            && (pick[c] >= ID_W'(NUM_PRIV)))
          lose[c] = 1'b1;
      end
      deactOk[c] = 1'b0;
      for (int i = 0; i < NUM_IRQ; i++) begin
        if (activeOn[c][i] && (deactIdFlat[c*ID_W +: ID_W] == ID_W'(i)))
          deactOk[c] = 1'b1;
      end
      ackIdFlat[c*ID_W +: ID_W] = lose[c] ? SPURIOUS_ID : pick[c];
      strobes[c].ack     = ackReq[c] & found[c] & ~lose[c];
      strobes[c].ackId   = pick[c];
      strobes[c].deact   = deactReq[c] & deactOk[c];
      strobes[c].deactId = deactIdFlat[c*ID_W +: ID_W];
    end
  end

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_chk
    assert_id_range_R2: assert property (@(posedge clk) disable iff (!rstN)
      (ackIdFlat[c*ID_W +: ID_W] == SPURIOUS_ID) ||
      (ackIdFlat[c*ID_W +: ID_W] < ID_W'(NUM_IRQ)));
  end
endmodule

// File: rtl/irqarb_top.sv
module irqarb_top
  import irqarb_pkg::*;
#(
  parameter int NUM_CORES  = 3,
  parameter int NUM_PRIV   = 4,
  parameter int NUM_SHARED = 4
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  logic                               globalEn,
  input  logic [NUM_PRIV+NUM_SHARED-1:0]     irqEnable,
  input  logic [NUM_PRIV+NUM_SHARED-1:0]     irqIsLevel,
  input  logic [NUM_CORES*NUM_PRIV-1:0]      privSrc,
  input  logic [NUM_SHARED-1:0]              sharedSrc,
  input  logic [NUM_CORES-1:0]               ackReq,
  output logic [NUM_CORES*10-1:0]            ackId,
  input  logic [NUM_CORES-1:0]               deactReq,
  input  logic [NUM_CORES*10-1:0]            deactId
);
  localparam int NUM_IRQ = NUM_PRIV + NUM_SHARED;

  coreStrobe_t [NUM_CORES-1:0] strobes;
  logic [NUM_CORES-1:0][NUM_IRQ-1:0] present, activeOn;

  irqarb_state #(.NUM_CORES(NUM_CORES), .NUM_PRIV(NUM_PRIV), .NUM_SHARED(NUM_SHARED))
  state_i (
    .clk(clk), .rstN(rstN), .globalEn(globalEn), .irqEnable(irqEnable),
    .irqIsLevel(irqIsLevel), .privSrc(privSrc), .sharedSrc(sharedSrc),
    .strobes(strobes), .present(present), .activeOn(activeOn)
  );

  irqarb_ctrl #(.NUM_CORES(NUM_CORES), .NUM_PRIV(NUM_PRIV), .NUM_SHARED(NUM_SHARED))
  ctrl_i (
    .clk(clk), .rstN(rstN), .ackReq(ackReq), .deactReq(deactReq),
    .deactIdFlat(deactId), .present(present), .activeOn(activeOn),
    .ackIdFlat(ackId), .strobes(strobes)
  );

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_chk
    assert_disabled_silent_R10: assert property (@(posedge clk) disable iff (!rstN)
      !globalEn |-> (ackId[c*ID_W +: ID_W] == SPURIOUS_ID));
  end
endmodule

// File: tb/irqarb_top_tb_top.sv
module irqarb_top_tb_top;
  localparam int NC = 3;
  localparam logic [9:0] SP = 10'd1023;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic globalEn = 1'b1;
  logic [7:0] irqEnable = 8'hFF;
  logic [7:0] irqIsLevel = 8'hFF;
  logic [11:0] privSrc = '0;
  logic [3:0] sharedSrc = '0;
  logic [NC-1:0] ackReq = '0;
  logic [NC*10-1:0] ackId;
  logic [NC-1:0] deactReq = '0;
  logic [NC*10-1:0] deactId = '0;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  irqarb_top dut_i (
    .clk(clk), .rstN(rstN), .globalEn(globalEn), .irqEnable(irqEnable),
    .irqIsLevel(irqIsLevel), .privSrc(privSrc), .sharedSrc(sharedSrc),
    .ackReq(ackReq), .ackId(ackId), .deactReq(deactReq), .deactId(deactId)
  );

  typedef struct packed {
    logic [11:0] priv;
    logic [3:0]  sh;
    logic        gEn;
    logic [7:0]  en;
    logic [9:0]  e0;
    logic [9:0]  e1;
    logic [9:0]  e2;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{12'h000, 4'h0, 1'b1, 8'hFF, SP,    SP,    SP},
    '{12'h020, 4'h0, 1'b1, 8'hFF, SP,    10'd1, SP},
    '{12'h008, 4'h4, 1'b1, 8'hFF, 10'd3, 10'd6, 10'd6},
    '{12'h000, 4'h9, 1'b1, 8'hFF, 10'd4, 10'd4, 10'd4},
    '{12'h000, 4'hA, 1'b1, 8'hDF, 10'd7, 10'd7, 10'd7},
    '{12'h555, 4'hF, 1'b0, 8'hFF, SP,    SP,    SP},
    '{12'h500, 4'h1, 1'b1, 8'hFF, 10'd4, 10'd4, 10'd0}
  };

  function automatic logic [9:0] idOf(int c);
    return ackId[c*10 +: 10];
  endfunction

  task automatic check(string tag, logic [9:0] act, logic [9:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    #1;
  endtask

  task automatic doDeact(int c, logic [9:0] id);
    deactReq[c] = 1'b1;
    deactId[c*10 +: 10] = id;
    step();
    deactReq = '0;
    #1;
  endtask

  task automatic doAck(int c);
    ackReq[c] = 1'b1;
    step();
    ackReq = '0;
    #1;
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      finishRun();
    end
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    #1;
    // R1: reset state
    for (int c = 0; c < NC; c++) check("R1 reset id", idOf(c), SP);
    rstN = 1'b1;
    step();
    for (int c = 0; c < NC; c++) check("R1 after reset", idOf(c), SP);

    // R2 / R10: table of static level-sensitive patterns
    foreach (VECS[v]) begin
      privSrc = VECS[v].priv;
      sharedSrc = VECS[v].sh;
      globalEn = VECS[v].gEn;
      irqEnable = VECS[v].en;
      step();
      check("R2 R10 table core0", idOf(0), VECS[v].e0);
      check("R2 R10 table core1", idOf(1), VECS[v].e1);
      check("R2 R10 table core2", idOf(2), VECS[v].e2);
    end
    privSrc = '0; sharedSrc = '0; globalEn = 1'b1; irqEnable = 8'hFF;
    step();

    // R3 R5 R9 R4: level shared ID 5
    sharedSrc[1] = 1'b1;
    step();
    check("R3 offered core1", idOf(1), 10'd5);
    ackReq[0] = 1'b1;
    #1;
    check("R3 grant core0", idOf(0), 10'd5);
    step();
    ackReq = '0;
    #1;
    check("R5 other core1", idOf(1), SP);
    check("R5 other core2", idOf(2), SP);
    check("R3 owner active", idOf(0), SP);
    doDeact(1, 10'd5);
    check("R9 non-owner deact", idOf(1), SP);
    check("R9 non-owner deact core0", idOf(0), SP);
    doDeact(0, 10'd5);
    check("R4 re-pend core0", idOf(0), 10'd5);
    check("R4 re-pend core2", idOf(2), 10'd5);
    sharedSrc[1] = 1'b0;
    step();
    check("R7 level drop", idOf(2), SP);

    // R8: same-cycle collision on shared ID 6 between cores 1 and 2
    sharedSrc[2] = 1'b1;
    step();
    ackReq[1] = 1'b1;
    ackReq[2] = 1'b1;
    #1;
    check("R8 winner core1", idOf(1), 10'd6);
    check("R8 loser core2", idOf(2), SP);
    step();
    ackReq = '0;
    #1;
    check("R8 claimed core0", idOf(0), SP);
    sharedSrc[2] = 1'b0;
    doDeact(2, 10'd6);
    check("R9 loser deact", idOf(0), SP);
    doDeact(1, 10'd6);
    step();
    check("R8 released", idOf(0), SP);

    // R6: private ID 2 on cores 0 and 1
    privSrc[2] = 1'b1;
    privSrc[6] = 1'b1;
    step();
    check("R6 core0 offered", idOf(0), 10'd2);
    doAck(0);
    check("R6 core0 active", idOf(0), SP);
    check("R6 core1 independent", idOf(1), 10'd2);
    check("R6 core2 none", idOf(2), SP);
    doDeact(0, 10'd2);
    check("R6 core0 re-pend", idOf(0), 10'd2);
    privSrc = '0;
    step();

    // R7 R4: edge-triggered shared ID 7
    irqIsLevel[7] = 1'b0;
    sharedSrc[3] = 1'b1;
    step();
    sharedSrc[3] = 1'b0;
    step();
    check("R7 edge latched", idOf(0), 10'd7);
    doAck(2);
    check("R7 edge claimed", idOf(0), SP);
    sharedSrc[3] = 1'b1;
    step();
    sharedSrc[3] = 1'b0;
    step();
    check("R4 active-pending hidden", idOf(1), SP);
    doDeact(2, 10'd7);
    check("R4 active-pending returns", idOf(1), 10'd7);
    doAck(1);
    doDeact(1, 10'd7);
    check("R7 edge no re-pend", idOf(0), SP);

    // R10: per-ID enable gates a latched edge
    irqEnable[7] = 1'b0;
    sharedSrc[3] = 1'b1;
    step();
    check("R10 disabled id", idOf(0), SP);
    irqEnable[7] = 1'b1;
    #1;
    check("R10 re-enabled id", idOf(0), 10'd7);

    done = 1'b1;
    finishRun();
  end
endmodule